// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

This block tracks the memory references of the stores placed in the dispatch group that is being formed, and tells the issue logic whether a candidate load would read bytes that one of those stores writes. Each reference is made of three parts:

- a base identifier;
- a signed byte offset from that base;
- an access size in bytes.

Two references can only conflict when their base identifiers are equal. When the bases match, the two byte ranges are compared for overlap. The block does no address arithmetic beyond this.

A store is recorded on the clock edge at which its strobe is high. A load query is answered combinationally in the same cycle, so the issue logic can hold the load or pad the group before the load is placed. When the group ends, a clear input empties the table. Only four stores are tracked per group. Stores that arrive after the table is full are not recorded.

Top module: `st_ld_overlap`

## Requirements
- R1: At most four stores are held per group. A store presented while four are held is dropped, and a later load matching only that store reports no hit.
- R2: A load whose base equals a held store's base and whose offset equals that store's offset hits. This holds for any sizes, including zero.
- R3: With equal bases and the store offset below the load offset, a hit occurs exactly when store offset plus store size is greater than the load offset.
- R4: With equal bases and the store offset at or above the load offset, a hit occurs exactly when load offset plus load size is greater than the store offset.
- R5: A load never hits a held store whose base identifier differs from its own.
- R6: A store strobed with its descriptor-present flag low is not recorded. A load with its descriptor-present flag low never hits.
- R7: After reset, and on the edge after group end is high, the table is empty and no load hits. A store strobed in the same cycle as group end is not recorded.
- R8: Offsets are 32-bit two's complement and sizes 8-bit unsigned. The end-of-range sums are formed without wraparound, so a store at 0x7FFFFFF0 with size 0x20 hits a load at 0x7FFFFFF8, and a load at 0x80000000 with size 0xFF does not hit it.
- R9: The hit output is high only while the load query input is high. A store strobed in the same cycle as a query is not seen by that query, but is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_end | input | 1 | Group boundary: empty the table |
| st_rec | input | 1 | Record-store strobe |
| st_has_ref | input | 1 | Store carries a memory reference descriptor |
| st_base | input | BASE_W | Store base identifier |
| st_ofs | input | OFS_W | Store signed offset |
| st_size | input | SIZE_W | Store size in bytes |
| ld_query | input | 1 | Load query valid |
| ld_has_ref | input | 1 | Load carries a memory reference descriptor |
| ld_base | input | BASE_W | Load base identifier |
| ld_ofs | input | OFS_W | Load signed offset |
| ld_size | input | SIZE_W | Load size in bytes |
| ld_hit | output | 1 | Load overlaps a held store |

## Verification
The only state is the fill count and the held entries, and both become visible through `ld_hit` on the first query after the store or clear that changed them. The effects of a wrong state depend on what went wrong:

- A count that fails to clear shows up as a hit on the first query of the next group.
- A count that keeps growing past four shows up as a hit against a fifth store that should have been dropped.
- A mis-written entry slot shows up as a missed hit against a store that was recorded.

Range errors show up only at the exact boundaries, where the end of one range equals the start of the other. Errors from 32-bit wrap show up only near the positive offset limit. The bench therefore places queries on both sides of each boundary.

// File: rtl/st_ld_overlap.sv
module st_ld_overlap #(
  parameter int ENTRIES = 4,
  parameter int BASE_W  = 16,
  parameter int OFS_W   = 32,
  parameter int SIZE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_end,
  input  logic              st_rec,
  input  logic              st_has_ref,
  input  logic [BASE_W-1:0] st_base,
  input  logic [OFS_W-1:0]  st_ofs,
  input  logic [SIZE_W-1:0] st_size,
  input  logic              ld_query,
  input  logic              ld_has_ref,
  input  logic [BASE_W-1:0] ld_base,
  input  logic [OFS_W-1:0]  ld_ofs,
  input  logic [SIZE_W-1:0] ld_size,
  output logic              ld_hit
);
  localparam int CNT_W = $clog2(ENTRIES + 1);
  localparam int EXT_W = OFS_W + 1;

  logic [CNT_W-1:0]  fill;
  logic [BASE_W-1:0] e_base [ENTRIES];
  logic [OFS_W-1:0]  e_ofs  [ENTRIES];
  logic [SIZE_W-1:0] e_size [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  wire st_take = st_rec && st_has_ref && !grp_end && (fill < CNT_W'(ENTRIES));

  always_ff @(posedge clk) begin
    if (!rst_n || grp_end)
      fill <= '0;
    else if (st_take)
      fill <= fill + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n) begin
        e_base[i] <= '0;
        e_ofs[i]  <= '0;
        e_size[i] <= '0;
      end else if (st_take && fill == CNT_W'(i)) begin
        e_base[i] <= st_base;
        e_ofs[i]  <= st_ofs;
        e_size[i] <= st_size;
      end
    end
  end

  wire signed [EXT_W-1:0] lo    = {ld_ofs[OFS_W-1], ld_ofs};
  wire signed [EXT_W-1:0] l_end = lo + $signed({{(EXT_W-SIZE_W){1'b0}}, ld_size});

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    wire signed [EXT_W-1:0] so    = {e_ofs[g][OFS_W-1], e_ofs[g]};
    wire signed [EXT_W-1:0] s_end = so + $signed({{(EXT_W-SIZE_W){1'b0}}, e_size[g]});
    wire live    = fill > CNT_W'(g);
    wire same_b  = e_base[g] == ld_base;
    wire overlap = (so == lo) || ((so < lo) ? (s_end > lo) : (l_end > so));
    assign hit_vec[g] = live && same_b && overlap;
  end

  assign ld_hit = ld_query && ld_has_ref && (|hit_vec);
endmodule

// File: rtl/st_ld_overlap_chk.sv
module st_ld_overlap_chk #(
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grp_end,
  input logic             st_rec,
  input logic             st_has_ref,
  input logic             ld_query,
  input logic             ld_has_ref,
  input logic             ld_hit,
  input logic [CNT_W-1:0] fill
);
  a_r1_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(ENTRIES));

  a_r1_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CNT_W'(ENTRIES) && !grp_end) |=> fill == CNT_W'(ENTRIES));

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rec && st_has_ref && !grp_end && fill < CNT_W'(ENTRIES)) |=> fill == $past(fill) + CNT_W'(1));

  a_r6_noref_store: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rec && !st_has_ref && !grp_end) |=> $stable(fill));

  a_r6_noref_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_has_ref |-> !ld_hit);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> fill == '0);

  a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fill == '0 |-> !ld_hit);

  a_r9_query_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_query |-> !ld_hit);
endmodule

bind st_ld_overlap st_ld_overlap_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .grp_end(grp_end), .st_rec(st_rec),
  .st_has_ref(st_has_ref), .ld_query(ld_query), .ld_has_ref(ld_has_ref),
  .ld_hit(ld_hit), .fill(fill)
);

// File: tb/st_ld_overlap_tb_top.sv
module st_ld_overlap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grp_end = 1'b0;
  logic        st_rec = 1'b0, st_has_ref = 1'b0;
  logic [15:0] st_base = '0;
  logic [31:0] st_ofs = '0;
  logic [7:0]  st_size = '0;
  logic        ld_query = 1'b0, ld_has_ref = 1'b0;
  logic [15:0] ld_base = '0;
  logic [31:0] ld_ofs = '0;
  logic [7:0]  ld_size = '0;
  logic        ld_hit;

  int checks = 0;
  int failures = 0;
  bit    exp_q [$];
  string tag_q [$];
  logic  sample = 1'b0;

  always #5 clk = ~clk;

  st_ld_overlap dut_i (
    .clk(clk), .rst_n(rst_n), .grp_end(grp_end),
    .st_rec(st_rec), .st_has_ref(st_has_ref), .st_base(st_base), .st_ofs(st_ofs), .st_size(st_size),
    .ld_query(ld_query), .ld_has_ref(ld_has_ref), .ld_base(ld_base), .ld_ofs(ld_ofs), .ld_size(ld_size),
    .ld_hit(ld_hit)
  );

  always @(negedge clk) begin
    if (sample && exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (ld_hit !== e) begin
        failures++;
        $display("FAIL %s: ld_hit actual=%b expected=%b", t, ld_hit, e);
      end
    end
  end

  task automatic idle_inputs();
    grp_end = 1'b0; st_rec = 1'b0; st_has_ref = 1'b0;
    ld_query = 1'b0; ld_has_ref = 1'b0; sample = 1'b0;
  endtask

  task automatic drive_store(input logic [15:0] b, input logic [31:0] o, input logic [7:0] s, input bit r);
    st_rec = 1'b1; st_has_ref = r; st_base = b; st_ofs = o; st_size = s;
  endtask

  task automatic drive_load(input bit q, input logic [15:0] b, input logic [31:0] o, input logic [7:0] s,
                            input bit r, input bit e, input string t);
    ld_query = q; ld_has_ref = r; ld_base = b; ld_ofs = o; ld_size = s;
    exp_q.push_back(e); tag_q.push_back(t); sample = 1'b1;
  endtask

  task automatic store(input logic [15:0] b, input logic [31:0] o, input logic [7:0] s, input bit r);
    @(posedge clk); #1; idle_inputs(); drive_store(b, o, s, r);
  endtask

  task automatic load(input logic [15:0] b, input logic [31:0] o, input logic [7:0] s,
                      input bit r, input bit e, input string t);
    @(posedge clk); #1; idle_inputs(); drive_load(1'b1, b, o, s, r, e, t);
  endtask

  task automatic end_group(input bit with_store, input logic [15:0] b);
    @(posedge clk); #1; idle_inputs(); grp_end = 1'b1;
    if (with_store) drive_store(b, 32'd0, 8'd4, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (ld_hit !== 1'b0) begin failures++; $display("FAIL R7 reset: ld_hit actual=%b expected=0", ld_hit); end
    load(16'd1, 32'd100, 8'd4, 1'b1, 1'b0, "R7 empty after reset");

    store(16'd1, 32'd100, 8'd8, 1'b1);
    load(16'd1, 32'd100, 8'd4, 1'b1, 1'b1, "R2 equal offset");
    load(16'd1, 32'd107, 8'd1, 1'b1, 1'b1, "R3 last store byte");
    load(16'd1, 32'd108, 8'd1, 1'b1, 1'b0, "R3 just past store");
    load(16'd1, 32'd96,  8'd4, 1'b1, 1'b0, "R4 load ends at store");
    load(16'd1, 32'd96,  8'd5, 1'b1, 1'b1, "R4 one byte overlap");
    load(16'd2, 32'd100, 8'd4, 1'b1, 1'b0, "R5 other base");
    load(16'd1, 32'd100, 8'd4, 1'b0, 1'b0, "R6 load without descriptor");
    @(posedge clk); #1; idle_inputs(); drive_load(1'b0, 16'd1, 32'd100, 8'd4, 1'b1, 1'b0, "R9 no query");

    @(posedge clk); #1; idle_inputs();
    drive_store(16'd3, 32'd0, 8'd4, 1'b1);
    drive_load(1'b1, 16'd3, 32'd0, 8'd4, 1'b1, 1'b0, "R9 same-cycle store unseen");
    load(16'd3, 32'd0, 8'd4, 1'b1, 1'b1, "R9 store seen next cycle");

    store(16'd4, 32'd0, 8'd4, 1'b0);
    load(16'd4, 32'd0, 8'd4, 1'b1, 1'b0, "R6 store without descriptor");
    store(16'd5, 32'd50, 8'd0, 1'b1);
    store(16'd6, 32'd0, 8'd4, 1'b1);
    store(16'd7, 32'd0, 8'd4, 1'b1);
    load(16'd7, 32'd0, 8'd4, 1'b1, 1'b0, "R1 fifth store dropped");
    load(16'd6, 32'd2, 8'd1, 1'b1, 1'b1, "R1 fourth store held");
    load(16'd5, 32'd50, 8'd0, 1'b1, 1'b1, "R2 zero sizes equal offset");

    end_group(1'b0, 16'd0);
    load(16'd1, 32'd100, 8'd4, 1'b1, 1'b0, "R7 cleared by group end");
    end_group(1'b1, 16'd8);
    load(16'd8, 32'd0, 8'd4, 1'b1, 1'b0, "R7 store with group end dropped");

    store(16'd9, 32'h7FFF_FFF0, 8'h20, 1'b1);
    load(16'd9, 32'h7FFF_FFF8, 8'd1, 1'b1, 1'b1, "R8 no wrap store end");
    load(16'd9, 32'h8000_0000, 8'hFF, 1'b1, 1'b0, "R8 most negative load");
    load(16'd9, 32'hFFFF_FFFF, 8'd2, 1'b1, 1'b0, "R4 negative load far below");

    @(posedge clk); #1; idle_inputs();
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule